// File: doc/BRIEF.md
# Always-on real-time clock with match wake

This block keeps time in an always-on power domain. A seconds counter 32 bits wide and a sub-second counter of `SUB_W` bits (15 by default) advance on a slow tick enable, which runs at 32.768 kHz in the intended system. One second therefore lasts 2^SUB_W ticks. A seconds match word and a sub-second match field are compared against the live count. When both are equal and match wake is enabled, a sticky status bit is set and a wake request is raised. An interrupt output is derived from that status through a mask. A bank of retained words holds data across a sleep period.

Software reaches the block through a simple byte-addressed register port. Reads return data combinationally, and writes take effect on the clock edge that samples them. Three mechanisms gate the port:
- A fixed hold-off after cold reset blocks every access.
- A write-ready flag drops after each accepted write for a number of slow ticks. Writes made while it is low are silently discarded.
- Until the slow-clock enable bit is set in control, only the control register responds.

A system reset input clears the block only when neither the RTC enable nor the pin-wake enable is set. The active-low cold reset always clears it.

Top module: `rtc_wake_top`

## Requirements
- R1: After cold reset release, no access is accepted for `HOLD` (3) clocks: reads return 0 and writes are dropped. After that, control (0x10) reads 0x80002000 and the seconds match (0x04) reads 0xFFFFFFFF once the clock enable is set.
- R2: While control bit 6 (clock enable) and bit 0 (RTC enable) are both set, each tick increments the sub-second counter. When it is at 2^SUB_W-1, a tick instead clears it and increments seconds. Seconds wrap from 0xFFFFFFFF to 0 without setting any status.
- R3: A write to 0x0C copies the data into the seconds counter and clears the sub-second counter. Seconds read at 0x00. Word 0x28 reads the sub-second match in bits [SUB_W-1:0] and the live sub-second count in bits [16+SUB_W-1:16].
- R4: While control bit 6 is clear, every register except control reads 0 and ignores writes, and no ignored write lowers the write-ready flag.
- R5: Control bit 31 is the write-ready flag. An accepted write clears it for `WR_TICKS` (2) ticks, and any write while it is clear is dropped.
- R6: Control bits are: 0 RTC enable, 1 sleep request (drives `hib_req`), 3 match wake enable, 4 pin-wake enable, 6 clock enable, and 13 fixed at 1. Writing 0x5B sets bits 0,1,3,4,6, and 0x52 sets bits 1,4,6.
- R7: When bit 3 is set and seconds equal 0x04 and sub-seconds equal the 0x28 match field, status bit 0 at 0x18 and `wake_req` rise one clock later and stay set. With bit 3 clear, equality sets nothing.
- R8: `irq` is status bit 0 ANDed with mask bit 0 at 0x14. Writing 1 to bit 0 of 0x20 clears the status, and a match in the same cycle wins.
- R9: Sixteen retained words at 0x30 to 0x6F read back what was written.
- R10: A low `sys_rst_n` clears all registers only when control bits 0 and 4 are both clear. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Cold reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low, qualified |
| tick | input | 1 | Slow-tick enable |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; must be word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wake_req | output | 1 | Sticky match wake request |
| irq | output | 1 | Masked match interrupt |
| hib_req | output | 1 | Sleep request bit from control |

## Verification
Writes land on the edge that samples them, so register reads, `irq` after a mask write, and status clearing are checked at the falling edge right after the write. Counter values are checked after each tick edge. The match status is checked one further clock after the tick that makes the count equal. The write-ready flag is read low just after a write and read high only after two full tick cycles. The bench waits out the hold-off before expecting any access to work. Because the bench uses a three-bit sub-second counter, a sweep over forty ticks crosses several second boundaries, and each step is compared with the arithmetic value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // word indices (byte address / 4)
  localparam logic [5:0] W_CNT   = 6'd0;
  localparam logic [5:0] W_MATCH = 6'd1;
  localparam logic [5:0] W_LOAD  = 6'd3;
  localparam logic [5:0] W_CTRL  = 6'd4;
  localparam logic [5:0] W_MASK  = 6'd5;
  localparam logic [5:0] W_RIS   = 6'd6;
  localparam logic [5:0] W_ICLR  = 6'd8;
  localparam logic [5:0] W_SUBM  = 6'd10;
  localparam logic [5:0] W_DATA0 = 6'd12;

  // control bit positions
  localparam int B_RTCEN = 0;
  localparam int B_HREQ  = 1;
  localparam int B_MWAKE = 3;
  localparam int B_PWAKE = 4;
  localparam int B_CLKEN = 6;
  localparam int B_RDY   = 31;

  localparam logic [31:0] CTRL_FIXED = 32'h0000_2000;

  typedef struct packed {
    logic rtc_en;
    logic hreq;
    logic mwake;
    logic pwake;
    logic clk_en;
  } ctrl_t;
endpackage

// File: rtl/rtc_wrgate.sv
module rtc_wrgate #(
  parameter int HOLD     = 3,
  parameter int WR_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qrst,
  input  logic tick,
  input  logic wr_acc,
  output logic access_ok,
  output logic wr_ready
);
  localparam int HW = $clog2(HOLD + 1);
  localparam int BW = $clog2(WR_TICKS + 1);

  logic [HW-1:0] hold_q, hold_n;
  logic [BW-1:0] busy_q, busy_n;

  always_comb begin
    hold_n = hold_q;
    if (hold_q != '0) hold_n = hold_q - HW'(1);
  end

  always_comb begin
    busy_n = busy_q;
    if (qrst)                       busy_n = '0;
    else if (wr_acc)                busy_n = BW'(WR_TICKS);
    else if (tick && busy_q != '0)  busy_n = busy_q - BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= HW'(HOLD);
      busy_q <= '0;
    end else begin
      hold_q <= hold_n;
      busy_q <= busy_n;
    end
  end

  assign access_ok = (hold_q == '0);
  assign wr_ready  = (busy_q == '0);

  // R5: an accepted write lowers the ready flag on the next cycle
  p_busy_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !qrst) |=> !wr_ready);

  // R1: no write is accepted during the hold-off window
  p_hold_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !access_ok |-> !wr_acc);
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int SUB_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qrst,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [31:0]      load_val,
  output logic [31:0]      sec,
  output logic [SUB_W-1:0] sub
);
  logic [31:0]      sec_q, sec_n;
  logic [SUB_W-1:0] sub_q, sub_n;

  always_comb begin
    sec_n = sec_q;
    sub_n = sub_q;
    if (qrst) begin
      sec_n = '0;
      sub_n = '0;
    end else if (load) begin
      sec_n = load_val;
      sub_n = '0;
    end else if (run && tick) begin
      if (sub_q == '1) begin
        sub_n = '0;
        sec_n = sec_q + 32'd1;
      end else begin
        sub_n = sub_q + SUB_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      sub_q <= '0;
    end else begin
      sec_q <= sec_n;
      sub_q <= sub_n;
    end
  end

  assign sec = sec_q;
  assign sub = sub_q;

  // R2: sub-second rollover carries into seconds
  p_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !load && !qrst && sub_q == '1)
      |=> (sub_q == '0 && sec_q == $past(sec_q) + 32'd1));

  // R3: a load sets seconds and clears the fraction
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !qrst) |=> (sec_q == $past(load_val) && sub_q == '0));
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int SUB_W  = 15,
  parameter int N_DATA = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             access_ok,
  input  logic             wr_ready,
  input  logic [31:0]      sec,
  input  logic [SUB_W-1:0] sub,
  output logic [31:0]      bus_rdata,
  output logic             wr_acc,
  output logic             load_stb,
  output ctrl_t            ctrl,
  output logic             wake_req,
  output logic             irq,
  output logic             qrst
);
  localparam logic [5:0] W_DEND = 6'(W_DATA0 + N_DATA);

  ctrl_t            ctrl_q, ctrl_n;
  logic [31:0]      match_q, match_n;
  logic [SUB_W-1:0] subm_q, subm_n;
  logic             mask_q, mask_n;
  logic             ris_q, ris_n;
  logic [31:0]      dat_q [N_DATA];
  logic [N_DATA-1:0] dat_we;

  logic [5:0] widx, doff;
  logic       aligned, is_ctrl, open_ok, rd_en, in_data, hit, clr;

  assign widx    = bus_addr[7:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign is_ctrl = (widx == W_CTRL);
  assign open_ok = access_ok && aligned && (is_ctrl || ctrl_q.clk_en);
  assign wr_acc  = bus_sel && bus_wr && open_ok && wr_ready;
  assign rd_en   = bus_sel && !bus_wr && open_ok;
  assign in_data = (widx >= W_DATA0) && (widx < W_DEND);
  assign doff    = widx - W_DATA0;

  assign qrst     = !sys_rst_n && !ctrl_q.rtc_en && !ctrl_q.pwake;
  assign load_stb = wr_acc && (widx == W_LOAD);
  assign hit      = ctrl_q.mwake && (sec == match_q) && (sub == subm_q);
  assign clr      = wr_acc && (widx == W_ICLR) && bus_wdata[0];

  always_comb begin
    ctrl_n  = ctrl_q;
    match_n = match_q;
    subm_n  = subm_q;
    mask_n  = mask_q;
    if (qrst) begin
      ctrl_n  = '0;
      match_n = '1;
      subm_n  = '0;
      mask_n  = 1'b0;
    end else if (wr_acc) begin
      case (widx)
        W_CTRL: begin
          ctrl_n.rtc_en = bus_wdata[B_RTCEN];
          ctrl_n.hreq   = bus_wdata[B_HREQ];
          ctrl_n.mwake  = bus_wdata[B_MWAKE];
          ctrl_n.pwake  = bus_wdata[B_PWAKE];
          ctrl_n.clk_en = bus_wdata[B_CLKEN];
        end
        W_MATCH: match_n = bus_wdata;
        W_SUBM:  subm_n  = bus_wdata[SUB_W-1:0];
        W_MASK:  mask_n  = bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    if (qrst) ris_n = 1'b0;
    else      ris_n = hit || (ris_q && !clr);
  end

  always_comb begin
    for (int i = 0; i < N_DATA; i++)
      dat_we[i] = wr_acc && in_data && (doff == 6'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      match_q <= '1;
      subm_q  <= '0;
      mask_q  <= 1'b0;
      ris_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      match_q <= match_n;
      subm_q  <= subm_n;
      mask_q  <= mask_n;
      ris_q   <= ris_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_DATA; i++) dat_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_DATA; i++) begin
        if (qrst)           dat_q[i] <= '0;
        else if (dat_we[i]) dat_q[i] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (widx)
        W_CNT:   bus_rdata = sec;
        W_MATCH: bus_rdata = match_q;
        W_CTRL: begin
          bus_rdata          = CTRL_FIXED;
          bus_rdata[B_RDY]   = wr_ready;
          bus_rdata[B_RTCEN] = ctrl_q.rtc_en;
          bus_rdata[B_HREQ]  = ctrl_q.hreq;
          bus_rdata[B_MWAKE] = ctrl_q.mwake;
          bus_rdata[B_PWAKE] = ctrl_q.pwake;
          bus_rdata[B_CLKEN] = ctrl_q.clk_en;
        end
        W_MASK:  bus_rdata[0] = mask_q;
        W_RIS:   bus_rdata[0] = ris_q;
        W_SUBM: begin
          bus_rdata[SUB_W-1:0]     = subm_q;
          bus_rdata[16+SUB_W-1:16] = sub;
        end
        default: begin
          for (int i = 0; i < N_DATA; i++)
            if (in_data && doff == 6'(i)) bus_rdata = dat_q[i];
        end
      endcase
    end
  end

  assign ctrl     = ctrl_q;
  assign wake_req = ris_q;
  assign irq      = ris_q && mask_q;

  // R5: writes arriving while not ready leave registers untouched
  p_drop_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !wr_ready && !qrst)
      |=> ($stable(match_q) && $stable(ctrl_q) && $stable(mask_q)));

  // R4: with the slow clock off only control can change
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !ctrl_q.clk_en && !is_ctrl && !qrst)
      |=> ($stable(match_q) && $stable(subm_q) && $stable(mask_q)));

  // R7: an enabled match sets the sticky status next cycle
  p_hit_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !qrst) |=> ris_q);

  // R10: a qualified system reset restores reset values
  p_qrst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    qrst |=> (ctrl_q == '0 && match_q == '1 && !ris_q));
endmodule

// File: rtl/rtc_wake_top.sv
module rtc_wake_top
  import rtc_pkg::*;
#(
  parameter int SUB_W    = 15,
  parameter int N_DATA   = 16,
  parameter int HOLD     = 3,
  parameter int WR_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sys_rst_n,
  input  logic        tick,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wake_req,
  output logic        irq,
  output logic        hib_req
);
  logic             access_ok, wr_ready, wr_acc, load_stb, qrst;
  ctrl_t            ctrl;
  logic [31:0]      sec;
  logic [SUB_W-1:0] sub;

  rtc_wrgate #(.HOLD(HOLD), .WR_TICKS(WR_TICKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .qrst(qrst), .tick(tick), .wr_acc(wr_acc),
    .access_ok(access_ok), .wr_ready(wr_ready)
  );

  rtc_counter #(.SUB_W(SUB_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .qrst(qrst),
    .run(ctrl.clk_en && ctrl.rtc_en), .tick(tick),
    .load(load_stb), .load_val(bus_wdata), .sec(sec), .sub(sub)
  );

  rtc_regs #(.SUB_W(SUB_W), .N_DATA(N_DATA)) u_regs (
    .clk(clk), .rst_n(rst_n), .sys_rst_n(sys_rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .access_ok(access_ok), .wr_ready(wr_ready),
    .sec(sec), .sub(sub), .bus_rdata(bus_rdata), .wr_acc(wr_acc),
    .load_stb(load_stb), .ctrl(ctrl), .wake_req(wake_req), .irq(irq),
    .qrst(qrst)
  );

  assign hib_req = ctrl.hreq;
endmodule

// File: tb/sim_rtc_wake_top.sv
module sim_rtc_wake_top;
  localparam int CLK_PERIOD = 10;
  localparam int SUB_W = 3;
  localparam int SPS   = 1 << SUB_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, sys_rst_n = 1'b1, tick = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wake_req, irq, hib_req;

  int n_chk = 0, n_fail = 0;
  logic [31:0] v;

  rtc_wake_top #(.SUB_W(SUB_W), .N_DATA(16), .HOLD(3), .WR_TICKS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sys_rst_n(sys_rst_n), .tick(tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_req(wake_req), .irq(irq), .hib_req(hib_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic wrt(input logic [7:0] a, input logic [31:0] d);
    wr(a, d);
    ticks(2);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic sys_pulse();
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: hold-off window
    rd(8'h10, v); chk("R1 read during hold-off", v, 32'h0);
    wr(8'h10, 32'h40);
    repeat (3) @(negedge clk);
    rd(8'h10, v); chk("R1 control reset value / hold-off write dropped", v, 32'h8000_2000);
    // R4: clock gate
    wr(8'h04, 32'h0);
    rd(8'h10, v); chk("R4 gated write keeps ready", v, 32'h8000_2000);
    rd(8'h04, v); chk("R4 gated read is zero", v, 32'h0);
    // R5: ready flag
    wr(8'h10, 32'h40);
    rd(8'h10, v); chk("R5 ready low after write", v, 32'h0000_2040);
    wr(8'h10, 32'h41);
    ticks(2);
    rd(8'h10, v); chk("R5 busy write dropped, ready back", v, 32'h8000_2040);
    rd(8'h04, v); chk("R1 match reset value", v, 32'hFFFF_FFFF);
    // R2/R3 counting sweep
    wrt(8'h10, 32'h41);
    wr(8'h0C, 32'd5);
    rd(8'h00, v); chk("R3 load seconds", v, 32'd5);
    rd(8'h28, v); chk("R3 load clears fraction", v, 32'h0);
    for (int k = 1; k <= 40; k++) begin
      ticks(1);
      rd(8'h00, v); chk("R2 seconds sweep", v, 32'(5 + k / SPS));
      rd(8'h28, v); chk("R2 fraction sweep", v, 32'(k % SPS) << 16);
    end
    // R2 wrap, R7 disabled match
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R3 load all ones", v, 32'hFFFF_FFFF);
    ticks(SPS);
    rd(8'h00, v); chk("R2 seconds wrap", v, 32'h0);
    rd(8'h18, v); chk("R7 no status with match wake off", v, 32'h0);
    chk("R2 wrap raises nothing", {31'b0, wake_req}, 32'h0);
    // R7/R8 match
    wrt(8'h04, 32'd7);
    wrt(8'h28, 32'd3);
    wrt(8'h14, 32'd0);
    wrt(8'h10, 32'h49);
    wr(8'h0C, 32'd7);
    ticks(2);
    rd(8'h18, v); chk("R7 no status before match", v, 32'h0);
    ticks(1);
    @(negedge clk);
    chk("R7 wake_req after match", {31'b0, wake_req}, 32'h1);
    rd(8'h18, v); chk("R7 status after match", v, 32'h1);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h14, 32'd1);
    chk("R8 irq after unmask", {31'b0, irq}, 32'h1);
    ticks(2);
    chk("R7 status sticky", {31'b0, wake_req}, 32'h1);
    wr(8'h20, 32'd1);
    chk("R8 clear drops irq", {31'b0, irq}, 32'h0);
    chk("R8 clear drops wake", {31'b0, wake_req}, 32'h0);
    ticks(2);
    // R6 control encodings
    wr(8'h10, 32'h5B);
    rd(8'h10, v); chk("R6 write 0x5B", v, 32'h0000_205B);
    chk("R6 sleep request", {31'b0, hib_req}, 32'h1);
    ticks(2);
    rd(8'h10, v); chk("R6 0x5B ready", v, 32'h8000_205B);
    // R9 retained words
    for (int i = 0; i < 16; i++) wrt(8'(8'h30 + 4 * i), 32'hC0DE_0000 + 32'(i) * 32'h111);
    for (int i = 0; i < 16; i++) begin
      rd(8'(8'h30 + 4 * i), v); chk("R9 data readback", v, 32'hC0DE_0000 + 32'(i) * 32'h111);
    end
    // R10 reset qualifier
    sys_pulse();
    for (int i = 0; i < 16; i++) begin
      rd(8'(8'h30 + 4 * i), v); chk("R10 retained with RTC enable", v, 32'hC0DE_0000 + 32'(i) * 32'h111);
    end
    rd(8'h10, v); chk("R10 control retained", v, 32'h8000_205B);
    wrt(8'h10, 32'h40);
    sys_pulse();
    rd(8'h10, v); chk("R10 control cleared", v, 32'h8000_2000);
    chk("R10 sleep request cleared", {31'b0, hib_req}, 32'h0);
    wrt(8'h10, 32'h40);
    rd(8'h30, v); chk("R10 data cleared", v, 32'h0);
    rd(8'h04, v); chk("R10 match cleared", v, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R10 seconds cleared", v, 32'h0);
    wrt(8'h10, 32'h52);
    rd(8'h10, v); chk("R6 write 0x52", v, 32'h8000_2052);
    wrt(8'h3C, 32'h1234);
    sys_pulse();
    rd(8'h3C, v); chk("R10 retained with pin wake", v, 32'h1234);
    rd(8'h10, v); chk("R10 control kept with pin wake", v, 32'h8000_2052);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule